// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Writes

This block is a single-port synchronous static memory with a flow-through read path. The array is organised as two 9-bit byte lanes per word. Lane a is data bits [8:0] and lane b is data bits [17:9]. The default build has a 10-bit address. Setting `ADDR_W` to 16 gives the full 64K-word by 18-bit organisation.

The rising clock edge registers the following:
- the address,
- the write data,
- every control input except the output enable and the burst-order pin.

A burst starts when either address strobe is low at the edge. The processor strobe `start_cpu_n` and the controller strobe `start_ctl_n` have the same effect, and the captured address becomes the burst base. While neither strobe is low, a low advance input steps a 2-bit burst counter. The counter rewrites the low two address bits in linear or interleaved order.

Writes are decided per lane from a write enable, two lane selects and a global write. The array takes the write at the edge that closes the cycle, so no external write pulse is needed. During a read cycle, the word at the current address flows straight to the output. The output drive enable is gated by the asynchronous output enable.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the burst counter clears and any pending write is discarded without reaching the array. From that edge until the next strobe, `dout_drive` is 0 and `dout` is all zeros.
- R2: In a read cycle, `dout` shows the stored word at the current burst address. It is valid in the same cycle in which the address was captured, with no extra output register.
- R3: A low `start_cpu_n`, a low `start_ctl_n`, or both low at a clock edge loads `addr` as the burst base and resets the burst count to 0. The current burst address then equals the captured `addr`.
- R4: With both strobes high, the burst count increments by one (mod 4) at an edge where `adv_n` is low. It holds where `adv_n` is high.
- R5: When `order_lin` is 1 (linear), the low two address bits are (base + count) mod 4. The upper bits stay equal to the base, so the fifth address in a burst repeats the first.
- R6: When `order_lin` is 0 (interleaved), the low two address bits are base XOR count. `order_lin` is not registered, so changing it mid-burst changes the current address at once.
- R7: Lane a (`lane_sel_n[0]`, bits [8:0]) is written only when `lane_sel_n[0]` and `we_n` are both low at the capturing edge. Lane b (`lane_sel_n[1]`, bits [17:9]) follows the same rule with `lane_sel_n[1]`. An unwritten lane keeps its old content.
- R8: A low `gw_n` writes both lanes regardless of `we_n` and `lane_sel_n`. Both lane selects low together with `we_n` low also writes both lanes.
- R9: Write data is captured with the address. The array is updated at the edge that ends the write cycle, so a read of that address in the next cycle returns the new word. Writes inside a burst go to the stepped addresses.
- R10: `dout_drive` is 1 only when `oe_n` is low, a burst has been started since reset, and the current cycle writes no lane. Otherwise `dout_drive` is 0 and `dout` is zero. `oe_n` acts without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, captured at a strobe |
| din | input | LANES*LANE_W | Write data, lane a in the low bits |
| start_cpu_n | input | 1 | Processor-side burst start strobe, active low |
| start_ctl_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Write enable qualifying the lane selects, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low, bit 0 is lane a |
| gw_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_drive | output | 1 | Drive enable for the external data pad buffer |

## Verification
The bench builds the block with `ADDR_W` = 6, `LANE_W` = 9 and `LANES` = 2. The 64-word array can then be filled completely through global writes and mirrored by a reference array in the bench. With that depth, the bench can reach the following cases:
- burst wrap-around in both orders,
- a switch of the order pin in the middle of a burst,
- every lane-select and global-write combination,
- writes whose targets come from the burst counter.

The two-lane split keeps the lane a and lane b paths in separate generate branches, so a fault in either lane shows up on its own bit field.

// File: rtl/sbs_pkg.sv
// Package: shared types and helpers of the synchronous burst memory.
// Assumes a burst window of four words, selected by the low two address bits.
package sbs_pkg;

    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_INC = 1'b1
    } burst_order_e;

    localparam int BURST_BITS = 2;

    // Maps a base offset and a burst count to the in-window offset.
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] base,
        input logic [BURST_BITS-1:0] count,
        input burst_order_e          order
    );
        if (order == ORDER_INC) begin
            return BURST_BITS'(base + count);
        end
        return base ^ count;
    endfunction

endpackage

// File: rtl/sbs_burst_ctr.sv
// Module: burst address register and 2-bit step counter.
// Captures the base address when either start strobe is low and then steps
// the counter on a low advance input. It maps count and base to the current
// address through the unregistered order pin. Assumes ADDR_W >= 2.
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              start_cpu_n,
    input  logic              start_ctl_n,
    input  logic              adv_n,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              active
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic                  active_q;
    logic                  start;
    burst_order_e          order;

    assign start = !start_cpu_n || !start_ctl_n;
    assign order = order_lin ? ORDER_INC : ORDER_XOR;

    // Purpose: load the base on a strobe, otherwise step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            base_q   <= addr;
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (!adv_n) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: build the current address from the fixed upper bits and the ordered offset.
    always_comb begin
        burst_addr = {base_q[ADDR_W-1 -: HI_W],
                      burst_offset(base_q[BURST_BITS-1:0], cnt_q, order)};
    end

    assign active = active_q;

    assert_start_loads_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu_n || !start_ctl_n) |=> (burst_addr == $past(addr)));

    assert_advance_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu_n && start_ctl_n && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 1)));

    assert_hold_without_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu_n && start_ctl_n && adv_n) |=> $stable(base_q) && $stable(cnt_q));

endmodule

// File: rtl/sbs_write_decode.sv
// Module: per-lane write decode and write data register.
// A lane is requested by a global write, or by its lane select together with
// the write enable. All inputs are active low. The request and data are
// registered so that the array commits them at the edge that ends the cycle.
module sbs_write_decode #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_n,
    input  logic                    gw_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES-1:0]        wr_lane_q,
    output logic [LANES*LANE_W-1:0] wdata_q
);

    logic [LANES-1:0] lane_req;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_req
        // Purpose: decode the write request of one lane.
        always_comb begin
            lane_req[g] = !gw_n || (!we_n && !lane_sel_n[g]);
        end
    end

    // Purpose: register lane requests and write data with the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lane_q <= '0;
            wdata_q   <= '0;
        end else begin
            wr_lane_q <= lane_req;
            wdata_q   <= din;
        end
    end

    assert_no_write_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && gw_n) |=> (wr_lane_q == '0));

    assert_global_writes_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |=> (wr_lane_q == '1));

endmodule

// File: rtl/sbs_array.sv
// Module: the lane-split storage array.
// Each lane has its own word array. A requested lane is written at the clock
// edge unless reset is low at that edge. Reads are combinational (flow-through).
// Assumes the read and write address of a cycle are the same.
module sbs_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Purpose: commit this lane's write at the end of the cycle.
        always_ff @(posedge clk) begin
            if (rst_n && wr_lane[g]) begin
                lane_mem[addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Purpose: flow the stored lane straight to the read bus.
        always_comb begin
            rd_data[g*LANE_W +: LANE_W] = lane_mem[addr];
        end

        assert_lane_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lane[g] |=> (lane_mem[$past(addr)] == $past(wr_data[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Module: top of the synchronous burst static memory.
// Ties together the burst counter, write decode and array. It gates the
// flow-through read data with the asynchronous output enable. Assumes the
// external pad buffer uses dout_drive as its enable.
module sync_burst_sram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    start_cpu_n,
    input  logic                    start_ctl_n,
    input  logic                    adv_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    gw_n,
    input  logic                    oe_n,
    input  logic                    order_lin,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic [ADDR_W-1:0] cur_addr;
    logic              active;
    logic [LANES-1:0]  wr_lane_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data;

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .adv_n       (adv_n),
        .order_lin   (order_lin),
        .burst_addr  (cur_addr),
        .active      (active)
    );

    sbs_write_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_wdec (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_n       (we_n),
        .gw_n       (gw_n),
        .lane_sel_n (lane_sel_n),
        .din        (din),
        .wr_lane_q  (wr_lane_q),
        .wdata_q    (wdata_q)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (cur_addr),
        .wr_lane (wr_lane_q),
        .wr_data (wdata_q),
        .rd_data (rd_data)
    );

    // Purpose: drive read data only in an enabled read cycle of a started burst.
    always_comb begin
        dout_drive = !oe_n && active && (wr_lane_q == '0);
        dout       = dout_drive ? rd_data : '0;
    end

    assert_write_cycle_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |=> !dout_drive);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !dout_drive);

endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;

    localparam int AW = 6;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          s_cpu;
        logic          s_ctl;
        logic          adv;
        logic          we;
        logic [1:0]    sel;
        logic          gw;
        logic          oe;
        logic          lin;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd5, 18'h0,4'd3},     // R3 cpu strobe read 5
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd5},     // R5 -> 6
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd5},     // R5 -> 7
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd5},     // R5 -> 4
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd5},     // R5 wrap -> 5
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,6'd9, 18'h0,4'd3},     // R3 ctl strobe 9
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,6'd0, 18'h0,4'd6},     // R6 -> 8
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,6'd0, 18'h0,4'd6},     // R6 -> 11
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,6'd0, 18'h0,4'd6},     // R6 -> 10
        '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,6'd0, 18'h0,4'd4},     // R4 hold
        '{1'b1,1'b0,1'b1,1'b0,2'b10,1'b1,1'b0,1'b1,6'd20,18'h2A5A5,4'd7}, // R7 lane a
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd20,18'h0,4'd7},
        '{1'b1,1'b0,1'b1,1'b0,2'b01,1'b1,1'b0,1'b1,6'd21,18'h15A5A,4'd7}, // R7 lane b
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd21,18'h0,4'd7},
        '{1'b1,1'b0,1'b1,1'b0,2'b11,1'b1,1'b0,1'b1,6'd22,18'h3FFFF,4'd7}, // R7 no lane
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd22,18'h0,4'd7},
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,1'b1,6'd23,18'h12345,4'd8}, // R8 global
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd23,18'h0,4'd8},
        '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b1,1'b0,1'b1,6'd24,18'h0ABCD,4'd8}, // R8 both selects
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd24,18'h0,4'd8},
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,6'd24,18'h0,4'd10},    // R10 oe high
        '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b1,1'b0,1'b1,6'd30,18'h11111,4'd9}, // R9 burst write
        '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,6'd0, 18'h22222,4'd9},
        '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,6'd0, 18'h33333,4'd9},
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd30,18'h0,4'd9},
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd9},
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd9},
        '{1'b0,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd40,18'h0,4'd3},     // R3 both strobes
        '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd13,18'h0,4'd6},     // R6 start 13
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,6'd0, 18'h0,4'd6},     // R6 switch -> 12
        '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0, 18'h0,4'd6},     // R6 pin back -> 14
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd63,18'h0,4'd2},     // R2 top word
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,6'd0, 18'h0,4'd2}      // R2 -> 62
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          start_cpu_n, start_ctl_n, adv_n, we_n, gw_n, oe_n, order_lin;
    logic [NL-1:0] lane_sel_n;
    logic [DW-1:0] dout;
    logic          dout_drive;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    bit            m_active;
    logic [NL-1:0] m_pend;
    logic [DW-1:0] m_pdata;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .adv_n(adv_n),
        .we_n(we_n), .lane_sel_n(lane_sel_n), .gw_n(gw_n), .oe_n(oe_n),
        .order_lin(order_lin), .dout(dout), .dout_drive(dout_drive)
    );

    // Current address from the requirement formulas (R5, R6).
    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = order_lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic drive(input vec_t v);
        start_cpu_n = v.s_cpu; start_ctl_n = v.s_ctl; adv_n = v.adv;
        we_n = v.we; lane_sel_n = v.sel; gw_n = v.gw; oe_n = v.oe;
        order_lin = v.lin; addr = v.a; din = v.d;
    endtask

    task automatic idle();
        drive('{1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd0,18'h0,4'd0});
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic cycle(input int req);
        logic [AW-1:0] wa;
        logic          exp_drv;
        logic [DW-1:0] exp_d;
        @(posedge clk);
        wa = model_addr();
        if (rst_n) begin
            for (int g = 0; g < NL; g++)
                if (m_pend[g]) ref_mem[wa][g*LW +: LW] = m_pdata[g*LW +: LW];
        end
        if (!rst_n) begin
            m_cnt = '0; m_active = 0; m_pend = '0; m_base = '0;
        end else begin
            if (!start_cpu_n || !start_ctl_n) begin
                m_base = addr; m_cnt = '0; m_active = 1;
            end else if (!adv_n) begin
                m_cnt = 2'(m_cnt + 1);
            end
            for (int g = 0; g < NL; g++)
                m_pend[g] = !gw_n || (!we_n && !lane_sel_n[g]);
            m_pdata = din;
        end
        @(negedge clk);
        exp_drv = !oe_n && m_active && (m_pend == '0);
        exp_d   = exp_drv ? ref_mem[model_addr()] : '0;
        checks++;
        if (dout_drive !== exp_drv || dout !== exp_d) begin
            fails++;
            $display("FAIL R%0d at %0t: actual drive=%b data=%h expected drive=%b data=%h",
                     req, $time, dout_drive, dout, exp_drv, exp_d);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=still running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        m_pend = '0; m_cnt = '0; m_base = '0; m_active = 0; m_pdata = '0;
        rst_n = 1'b0;
        idle();
        // R1 reset state, with strobes active during reset
        start_ctl_n = 1'b0;
        cycle(1);
        cycle(1);
        rst_n = 1'b1;
        idle();
        // R1 no burst started yet: advancing alone must not enable the drive
        adv_n = 1'b0;
        cycle(1);
        // Preload every word through global writes (R8)
        for (int i = 0; i < DEPTH; i++) begin
            drive('{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,1'b1,AW'(i),
                    DW'(i * 18'h01A3 + 18'h0155),4'd8});
            cycle(8);
        end
        // Vector table
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k]);
            cycle(int'(VECS[k].req));
        end
        // R1 pending write dropped by reset
        drive('{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,1'b1,6'd50,18'h3C3C3,4'd1});
        cycle(1);
        idle();
        rst_n = 1'b0;
        cycle(1);
        rst_n = 1'b1;
        drive('{1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,6'd50,18'h0,4'd1});
        cycle(1);
        // R10 output enable acts without a clock
        oe_n = 1'b1;
        #0.5;
        checks++;
        if (dout_drive !== 1'b0 || dout !== '0) begin
            fails++;
            $display("FAIL R10: actual drive=%b data=%h expected drive=0 data=0",
                     dout_drive, dout);
        end
        oe_n = 1'b0;
        #0.5;
        checks++;
        if (dout_drive !== 1'b1 || dout !== ref_mem[50]) begin
            fails++;
            $display("FAIL R10: actual drive=%b data=%h expected drive=1 data=%h",
                     dout_drive, dout, ref_mem[50]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule